// File: doc/BRIEF.md
# Multi-source event fragment builder

This block merges the per-trigger output of eight timing front-end sources into one event fragment per trigger. Each source delivers a stream of 32-bit words. For every trigger a source sends one tag word that holds the trigger number, then zero or more data words, and it marks the last word of that trigger with an end flag. The builder visits the sources in a fixed ascending order. It frames their data with a header and a trailer and writes the result into an internal 64-bit output FIFO that a host bus reads.

A fragment counter tracks how many complete fragments wait in the FIFO. An interrupt line rises when that count reaches a programmable threshold. The block cross-checks the trigger numbers from all sources and flags any disagreement in the trailer. When the FIFO is full, assembly pauses and no word is dropped.

Output word layout: bits [63:62] hold the kind (01 header, 00 data, 11 trailer). A header carries the trigger number in [15:0]. A data word carries the source index in [34:32] and the source word in [31:0]. A trailer carries the error flag in bit 61 and the data word count in [15:0]. All other bits are zero.

Top module: `evt_frag_builder`

## Requirements
- R1: Each fragment starts with a header word (kind 01) whose bits [15:0] equal the tag word of source 0, taken from bits [15:0] of that tag.
- R2: After the header, each source's data words follow in source order 0 to 7 and in arrival order. Each is written as kind 00 with the source index in [34:32] and the word in [31:0]. A source is drained until the word that carries its end flag.
- R3: Each fragment ends with a trailer (kind 11) that holds the number of data words in [15:0]. Bit 61 is set exactly when some source's tag bits [15:0] differ from those of source 0.
- R4: While the output FIFO is full, no source word is accepted (src_ready stays 0 for data) and no word is lost. Every word appears once space is freed.
- R5: The output FIFO holds up to 512 words and shows its oldest word on rd_data. rd_valid is 1 when it is not empty, and rd_en with rd_valid removes that word.
- R6: frag_count rises by one when a trailer is written and falls by one when the host removes a trailer.
- R7: irq is 1 exactly when irq_thresh is nonzero and frag_count is at least irq_thresh. It drops as soon as the count falls below the threshold, and it stays 0 when the threshold is 0.
- R8: A source whose tag word already carries the end flag adds no data words, and the builder moves on to the next source.
- R9: After reset, rd_valid, frag_count, irq and src_ready are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_valid | input | 8 | Per-source word present |
| src_ready | output | 8 | Per-source word taken this cycle |
| src_data | input | 256 | Per-source 32-bit words, source s at [32*s+31:32*s] |
| src_last | input | 8 | Per-source end-of-trigger flag on the current word |
| rd_en | input | 1 | Host removes the word on rd_data |
| rd_data | output | 64 | Oldest output FIFO word |
| rd_valid | output | 1 | Output FIFO not empty |
| irq_thresh | input | 10 | Fragment count that raises irq; 0 disables |
| frag_count | output | 10 | Complete fragments waiting in the FIFO |
| irq | output | 1 | Fragment threshold reached |

## Verification
Assembly is driven from a table of trigger patterns:
- uniform one-word sources;
- all sources with empty events;
- uneven counts, including fifteen-word runs;
- a single-source event.

These patterns separate errors in source order, word count and end-of-trigger handling. Two vectors corrupt a tag: one on a middle source and one on source 0. Between them they show that the error bit compares against source 0 and that the header takes its number from that source. An event larger than the FIFO, with no reads for hundreds of cycles, shows the stall and then the loss-free resume. Two back-to-back fragments under thresholds of 2, 1 and 0 show the interrupt rising and falling with the fragment count.

// File: rtl/efb_pkg.sv
package efb_pkg;
  localparam int OUT_W  = 64;
  localparam int TRIG_W = 16;
  localparam int CNT_W  = 16;

  typedef enum logic [1:0] {
    K_DATA = 2'b00,
    K_HDR  = 2'b01,
    K_TRL  = 2'b11
  } word_kind_e;

  typedef enum logic [1:0] {
    S_HDR,
    S_TAG,
    S_COPY,
    S_TRL
  } asm_state_e;
endpackage

// File: rtl/efb_out_fifo.sv
module efb_out_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 512
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          push, pop;

  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;
  assign rd_data = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = wp_q + 1'b1;
    if (pop)  rp_d = rp_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wr_data;
  end

  // R4: the assembler never offers a word to a full buffer
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    full |-> !wr_en);
endmodule

// File: rtl/efb_assembler.sv
module efb_assembler
  import efb_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int SRC_DW = 32
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic [N_SRC-1:0]              src_valid,
  input  logic [N_SRC-1:0][SRC_DW-1:0]  src_words,
  input  logic [N_SRC-1:0]              src_last,
  output logic [N_SRC-1:0]              src_ready,
  input  logic                          room,
  output logic                          wr_en,
  output logic [OUT_W-1:0]              wr_data
);
  localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [SW-1:0] LAST_SEL = SW'(N_SRC - 1);

  asm_state_e         state_q, state_d;
  logic [SW-1:0]      sel_q, sel_d;
  logic [TRIG_W-1:0]  ref_q, ref_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               err_q, err_d;
  logic               cur_valid, cur_last, last_src;
  logic [SRC_DW-1:0]  cur_word;

  assign cur_valid = src_valid[sel_q];
  assign cur_last  = src_last[sel_q];
  assign cur_word  = src_words[sel_q];
  assign last_src  = (sel_q == LAST_SEL);

  always_comb begin
    state_d   = state_q;
    sel_d     = sel_q;
    ref_d     = ref_q;
    cnt_d     = cnt_q;
    err_d     = err_q;
    src_ready = '0;
    wr_en     = 1'b0;
    wr_data   = '0;
    case (state_q)
      S_HDR: if (cur_valid && room) begin
        wr_en = 1'b1;
        wr_data[OUT_W-1 -: 2]  = K_HDR;
        wr_data[TRIG_W-1:0]    = cur_word[TRIG_W-1:0];
        src_ready[sel_q] = 1'b1;
        ref_d = cur_word[TRIG_W-1:0];
        cnt_d = '0;
        err_d = 1'b0;
        if (!cur_last) state_d = S_COPY;
        else if (last_src) state_d = S_TRL;
        else begin sel_d = sel_q + 1'b1; state_d = S_TAG; end
      end
      S_TAG: if (cur_valid) begin
        src_ready[sel_q] = 1'b1;
        err_d = err_q | (cur_word[TRIG_W-1:0] != ref_q);
        if (!cur_last) state_d = S_COPY;
        else if (last_src) state_d = S_TRL;
        else begin sel_d = sel_q + 1'b1; state_d = S_TAG; end
      end
      S_COPY: if (cur_valid && room) begin
        wr_en = 1'b1;
        wr_data[OUT_W-1 -: 2]  = K_DATA;
        wr_data[SRC_DW +: SW]  = sel_q;
        wr_data[SRC_DW-1:0]    = cur_word;
        src_ready[sel_q] = 1'b1;
        cnt_d = cnt_q + 1'b1;
        if (cur_last) begin
          if (last_src) state_d = S_TRL;
          else begin sel_d = sel_q + 1'b1; state_d = S_TAG; end
        end
      end
      default: if (room) begin
        wr_en = 1'b1;
        wr_data[OUT_W-1 -: 2] = K_TRL;
        wr_data[OUT_W-3]      = err_q;
        wr_data[CNT_W-1:0]    = cnt_q;
        sel_d   = '0;
        state_d = S_HDR;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HDR;
      sel_q   <= '0;
      ref_q   <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      ref_q   <= ref_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
    end
  end

  // R2: at most one source is drained per cycle
  p_single_src_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(src_ready));
  // R2: the source pointer only steps up by one or restarts at zero
  p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> (sel_q == $past(sel_q) + 1'b1 || sel_q == '0));
endmodule

// File: rtl/efb_frag_counter.sv
module efb_frag_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          trl_wr,
  input  logic          trl_rd,
  input  logic [CW-1:0] thresh,
  output logic [CW-1:0] count,
  output logic          irq
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    case ({trl_wr, trl_rd})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign irq   = (thresh != '0) && (cnt_q >= thresh);

  // R6: a written trailer alone raises the count by one
  p_cnt_up_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (trl_wr && !trl_rd) |=> (count == $past(count) + 1'b1));
  // R6: a removed trailer alone lowers the count by one
  p_cnt_down_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (trl_rd && !trl_wr) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/evt_frag_builder.sv
module evt_frag_builder
  import efb_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int SRC_DW    = 32,
  parameter int OUT_DEPTH = 512,
  localparam int FC_W     = $clog2(OUT_DEPTH) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SRC-1:0]          src_valid,
  output logic [N_SRC-1:0]          src_ready,
  input  logic [N_SRC*SRC_DW-1:0]   src_data,
  input  logic [N_SRC-1:0]          src_last,
  input  logic                      rd_en,
  output logic [OUT_W-1:0]          rd_data,
  output logic                      rd_valid,
  input  logic [FC_W-1:0]           irq_thresh,
  output logic [FC_W-1:0]           frag_count,
  output logic                      irq
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [N_SRC-1:0][SRC_DW-1:0] src_words;
  logic             wr_en, full, empty, trl_wr, trl_rd;
  logic [OUT_W-1:0] wr_data;

  assign src_words = src_data;

  efb_assembler #(.N_SRC(N_SRC), .SRC_DW(SRC_DW)) u_asm (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .src_valid (src_valid),
    .src_words (src_words),
    .src_last  (src_last),
    .src_ready (src_ready),
    .room      (!full),
    .wr_en     (wr_en),
    .wr_data   (wr_data)
  );

  efb_out_fifo #(.W(OUT_W), .DEPTH(OUT_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .full    (full),
    .empty   (empty)
  );

  assign rd_valid = !empty;
  assign trl_wr   = wr_en && !full && (wr_data[OUT_W-1 -: 2] == K_TRL);
  assign trl_rd   = rd_en && !empty && (rd_data[OUT_W-1 -: 2] == K_TRL);

  efb_frag_counter #(.CW(FC_W)) u_cnt (
    .clk    (clk),
    .rst_ni (rst_ni),
    .trl_wr (trl_wr),
    .trl_rd (trl_rd),
    .thresh (irq_thresh),
    .count  (frag_count),
    .irq    (irq)
  );
endmodule

// File: tb/evt_frag_builder_test.sv
module evt_frag_builder_test;
  localparam int NS    = 8;
  localparam int DW    = 32;
  localparam int DEPTH = 512;
  localparam int FCW   = 10;
  localparam int SM    = 256;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n;
  logic [NS-1:0]      src_valid, src_ready, src_last;
  logic [NS*DW-1:0]   src_data;
  logic               rd_en;
  logic [63:0]        rd_data;
  logic               rd_valid;
  logic [FCW-1:0]     irq_thresh, frag_count;
  logic               irq;

  evt_frag_builder #(.N_SRC(NS), .SRC_DW(DW), .OUT_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .src_last(src_last), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .irq_thresh(irq_thresh), .frag_count(frag_count), .irq(irq)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // source models
  logic [DW-1:0] smem  [NS][SM];
  logic          slast [NS][SM];
  int            wcnt  [NS];
  int            rcnt  [NS];

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      src_valid[s]        = rcnt[s] < wcnt[s];
      src_data[s*DW +: DW] = smem[s][rcnt[s] % SM];
      src_last[s]         = slast[s][rcnt[s] % SM];
    end
  end

  always @(posedge clk) begin
    for (int s = 0; s < NS; s++) begin
      if (!rst_n) rcnt[s] <= 0;
      else if (src_valid[s] && src_ready[s]) rcnt[s] <= rcnt[s] + 1;
    end
  end

  logic [63:0] expq [$];

  task automatic add_event(input logic [15:0] trig, input logic [31:0] pat, input int bad, input int mult);
    int total = 0;
    logic [15:0] t0;
    bit err;
    err = (bad < NS);
    t0 = (bad == 0) ? (trig ^ 16'h00FF) : trig;
    expq.push_back({2'b01, 46'b0, t0});
    for (int s = 0; s < NS; s++) begin
      logic [15:0] tag;
      int n;
      tag = (s == bad) ? (trig ^ 16'h00FF) : trig;
      n = int'(pat[4*s +: 4]) * mult;
      smem[s][wcnt[s] % SM]  = {16'h0, tag};
      slast[s][wcnt[s] % SM] = (n == 0);
      wcnt[s]++;
      for (int k = 0; k < n; k++) begin
        logic [31:0] d;
        d = {8'(s), 8'(k), trig};
        smem[s][wcnt[s] % SM]  = d;
        slast[s][wcnt[s] % SM] = (k == n - 1);
        wcnt[s]++;
        expq.push_back({2'b00, 27'b0, 3'(s), d});
      end
      total += n;
    end
    expq.push_back({2'b11, err, 45'b0, 16'(total)});
  endtask

  task automatic pop_check(input string req);
    logic [63:0] e;
    e = expq.pop_front();
    while (!rd_valid) @(negedge clk);
    chk(rd_data === e, req, rd_data, e);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_count(input int v);
    while (int'(frag_count) != v) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected < %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // {trigger[15:0], per-source data count nibbles[31:0], bad source[3:0] (8 = none)}
  localparam logic [51:0] VEC [6] = '{
    {16'h0011, 32'h11111111, 4'd8},
    {16'h0022, 32'h00000000, 4'd8},
    {16'h1234, 32'h3010F020, 4'd8},
    {16'h00AB, 32'h21212121, 4'd3},
    {16'hFFFF, 32'hF000000F, 4'd0},
    {16'h0100, 32'h00000001, 4'd8}
  };

  initial begin
    for (int s = 0; s < NS; s++) wcnt[s] = 0;
    rd_en = 1'b0;
    irq_thresh = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk(rd_valid == 1'b0, "R9 rd_valid after reset", 64'(rd_valid), 64'd0);
    chk(frag_count == '0, "R9 frag_count after reset", 64'(frag_count), 64'd0);
    chk(irq == 1'b0, "R9 irq after reset", 64'(irq), 64'd0);
    chk(src_ready == '0, "R9 src_ready after reset", 64'(src_ready), 64'd0);

    // table walk: R1 R2 R3 R8 with R6 counting
    for (int i = 0; i < 6; i++) begin
      add_event(VEC[i][51:36], VEC[i][35:4], int'(VEC[i][3:0]), 1);
      wait_count(1);
      chk(irq == 1'b0, "R7 threshold zero keeps irq low", 64'(irq), 64'd0);
      while (expq.size() > 0) pop_check("R1 R2 R3 R8 fragment word");
      chk(frag_count == '0, "R6 count after trailer read", 64'(frag_count), 64'd0);
      chk(rd_valid == 1'b0, "R5 empty after drain", 64'(rd_valid), 64'd0);
    end

    // R7 interrupt threshold
    irq_thresh = 10'd2;
    add_event(16'h0A01, 32'h00000001, 8, 1);
    add_event(16'h0A02, 32'h00000001, 8, 1);
    wait_count(1);
    chk(irq == 1'b0, "R7 irq below threshold", 64'(irq), 64'd0);
    wait_count(2);
    chk(irq == 1'b1, "R7 irq at threshold", 64'(irq), 64'd1);
    for (int k = 0; k < 3; k++) pop_check("R7 first fragment word");
    chk(frag_count == 10'd1, "R6 count after one trailer read", 64'(frag_count), 64'd1);
    chk(irq == 1'b0, "R7 irq drops below threshold", 64'(irq), 64'd0);
    irq_thresh = 10'd1;
    @(negedge clk);
    chk(irq == 1'b1, "R7 irq with threshold one", 64'(irq), 64'd1);
    while (expq.size() > 0) pop_check("R7 second fragment word");
    chk(irq == 1'b0, "R7 irq after last fragment read", 64'(irq), 64'd0);
    irq_thresh = '0;

    // R4 back-pressure: 562 words into a 512-word buffer with no reads
    add_event(16'h0777, 32'h77777777, 8, 10);
    repeat (800) @(negedge clk);
    chk(rd_valid == 1'b1, "R5 rd_valid with stored words", 64'(rd_valid), 64'd1);
    chk(src_ready == '0, "R4 sources held while full", 64'(src_ready), 64'd0);
    chk(frag_count == '0, "R4 no trailer while stalled", 64'(frag_count), 64'd0);
    while (expq.size() > 0) pop_check("R4 word after stall");
    chk(frag_count == '0, "R6 count after large fragment", 64'(frag_count), 64'd0);

    finish_run();
  end
endmodule